// File: doc/BRIEF.md
# Interrupt Stack Frame Sequencer

This block runs the byte-wide stack traffic that surrounds interrupt entry and interrupt return for a CPU whose code addresses are built from a segment register and a 16-bit offset. On entry it saves the interrupted program counter and flags to a downward-growing stack. On return it reads them back and hands them to the CPU through write-enable pulses. A mode bit chooses between two frame layouts. The compact layout saves only PC and flags, and the handler fetches code from the interrupt segment register in place of the code segment register. The extended layout also saves the old code segment register and reloads that register from the interrupt segment register, so handlers may move across the whole segmented space.

The mode bit is captured for each entry, and one bit per nesting level records which layout was used. A return therefore always reads back a frame of the size that was written, even if software flips the mode bit inside the handler. The block keeps its own stack pointer. It drives the memory port directly and reads return data from an asynchronous read path. It also reports the segment to use for instruction fetch and the segment that holds the vector table.

Top module: `intr_frame_seq`

## Requirements
- R1: After reset the mode bit is 0, busy_o is low, no stack access or write-enable pulse is issued, sp_o equals SP_INIT, and fetch_seg_o follows csr_i.
- R2: An accepted request with the mode bit at 0 holds busy_o high for exactly 3 cycles and writes PC bits 7:0 at sp-1, PC bits 15:8 at sp-2 and flags at sp-3. It then leaves sp_o lower by 3 and issues no csr_we_o pulse.
- R3: An accepted request with the mode bit at 1 holds busy_o high for exactly 4 cycles and writes the same three bytes plus the zero-extended csr_i at sp-4. In the cycle after busy_o falls it pulses csr_we_o with csr_o equal to the isr_i value that was sampled at acceptance, and sp_o ends lower by 4.
- R4: While the innermost active level used the compact frame, fetch_seg_o equals isr_i. Otherwise (no active level, or an extended innermost level) it equals csr_i.
- R5: An accepted return reads ascending addresses starting at sp_o, in exact reverse order of the pushes. In the cycle after busy_o falls it pulses pc_we_o and flags_we_o with the saved values, and for an extended frame it also pulses csr_we_o with the saved segment. sp_o returns to its value before the entry.
- R6: The frame type is taken from the mode bit at acceptance. Changing the mode bit inside a handler does not change the number of bytes popped or whether csr_we_o pulses on return.
- R7: vec_seg_o always equals isr_i.
- R8: A return strobe while no level is active is ignored: busy_o stays low, no stack write occurs, no write-enable pulse is issued, and sp_o is unchanged.
- R9: A request while NEST_DEPTH levels are active is ignored in the same way as in R8.
- R10: When a request and a return strobe arrive together while idle, the request is taken.
- R11: Stack write and stack read are never active together, and neither is active while busy_o is low.
- R12: Frames nest: up to NEST_DEPTH entries can stack, and the returns then restore each frame in last-in first-out order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_we_i | input | 1 | Write strobe for the frame mode bit |
| mode_d_i | input | 1 | New mode bit value (1 = extended frame) |
| irq_i | input | 1 | Interrupt entry request, taken when idle |
| iret_i | input | 1 | Interrupt return strobe, taken when idle |
| pc_i | input | PC_W | Current program counter |
| flags_i | input | FLAG_W | Current flags |
| csr_i | input | SEG_W | Current code segment register |
| isr_i | input | SEG_W | Interrupt segment register |
| stk_we_o | output | 1 | Stack byte write |
| stk_re_o | output | 1 | Stack byte read |
| stk_addr_o | output | SP_W | Stack byte address |
| stk_wdata_o | output | 8 | Stack write byte |
| stk_rdata_i | input | 8 | Stack read byte, valid in the same cycle as the address |
| sp_o | output | SP_W | Stack pointer (points at the last byte pushed) |
| busy_o | output | 1 | Push or pop sequence in progress |
| pc_we_o | output | 1 | Load PC from pc_o |
| pc_o | output | PC_W | Restored program counter |
| flags_we_o | output | 1 | Load flags from flags_o |
| flags_o | output | FLAG_W | Restored flags |
| csr_we_o | output | 1 | Load code segment register from csr_o |
| csr_o | output | SEG_W | New code segment value |
| fetch_seg_o | output | SEG_W | Segment in use for instruction fetch |
| vec_seg_o | output | SEG_W | Segment of the vector table |

## Verification
The checker assumes that the stack memory returns the byte at stk_addr_o in the same cycle. It also assumes the CPU holds no request or return strobe that it expects to be taken while busy_o is high or during the write-back cycle, because strobes in those cycles are dropped. The bench keeps every strobe to one cycle issued from idle, and it models the memory as an asynchronous-read array. The CPU's code segment register is modelled as a register loaded on csr_we_o, so csr_i moves as a real CPU would. Random operations never exceed the nesting limit except in the directed cases that test that the block ignores them.

// File: rtl/ifs_pkg.sv
package ifs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUSH = 2'd1,
    ST_POP  = 2'd2,
    ST_WB   = 2'd3
  } ifs_state_e;
endpackage

// File: rtl/ifs_level_stack.sv
module ifs_level_stack #(
  parameter int unsigned NEST_DEPTH = 8,
  localparam int unsigned DEPTH_W   = $clog2(NEST_DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               push_i,
  input  logic               pop_i,
  input  logic               ext_i,
  output logic [DEPTH_W-1:0] depth_o,
  output logic               full_o,
  output logic               empty_o,
  output logic               top_ext_o
);
  logic [NEST_DEPTH-1:0] ext_q;
  logic [DEPTH_W-1:0]    depth_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_q   <= '0;
      depth_q <= '0;
    end else if (push_i && !full_o) begin
      ext_q[depth_q] <= ext_i;
      depth_q        <= depth_q + 1'b1;
    end else if (pop_i && !empty_o) begin
      depth_q <= depth_q - 1'b1;
    end
  end

  assign depth_o   = depth_q;
  assign full_o    = (depth_q == DEPTH_W'(NEST_DEPTH));
  assign empty_o   = (depth_q == '0);
  assign top_ext_o = empty_o ? 1'b0 : ext_q[depth_q - 1'b1];
endmodule

// File: rtl/ifs_frame_mux.sv
module ifs_frame_mux #(
  parameter int unsigned PC_W   = 16,
  parameter int unsigned FLAG_W = 8,
  parameter int unsigned SEG_W  = 6,
  parameter int unsigned SP_W   = 8,
  localparam int unsigned PC_BYTES = PC_W / 8,
  localparam int unsigned IDX_W    = $clog2(PC_BYTES + 2)
) (
  input  logic              push_i,
  input  logic              ext_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [SP_W-1:0]   sp_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [SEG_W-1:0]  seg_i,
  output logic [IDX_W-1:0]  sel_o,
  output logic [SP_W-1:0]   addr_o,
  output logic [7:0]        wdata_o
);
  logic [IDX_W-1:0] last_idx;
  logic [PC_W-1:0]  pc_shift;

  assign last_idx = IDX_W'(PC_BYTES) + IDX_W'(ext_i);
  // pops walk the push order backwards
  assign sel_o    = push_i ? idx_i : (last_idx - idx_i);
  assign addr_o   = push_i ? (sp_i - SP_W'(1) - SP_W'(idx_i)) : (sp_i + SP_W'(idx_i));
  assign pc_shift = pc_i >> (8 * int'(sel_o));

  always_comb begin
    wdata_o = '0;
    if (int'(sel_o) < PC_BYTES) begin
      wdata_o = pc_shift[7:0];
    end else if (int'(sel_o) == PC_BYTES) begin
      wdata_o[FLAG_W-1:0] = flags_i;
    end else begin
      wdata_o[SEG_W-1:0] = seg_i;
    end
  end
endmodule

// File: rtl/ifs_ctrl.sv
module ifs_ctrl import ifs_pkg::*; #(
  parameter int unsigned PC_BYTES = 2,
  localparam int unsigned IDX_W   = $clog2(PC_BYTES + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             irq_i,
  input  logic             iret_i,
  input  logic             mode_i,
  input  logic             full_i,
  input  logic             empty_i,
  input  logic             top_ext_i,
  output ifs_state_e       state_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             ext_o,
  output logic             entry_o,
  output logic             start_push_o,
  output logic             finish_o
);
  ifs_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic             ext_q;
  logic             entry_q;
  logic             start_pop;
  logic [IDX_W-1:0] last_idx;

  assign start_push_o = (state_q == ST_IDLE) && irq_i && !full_i;
  assign start_pop    = (state_q == ST_IDLE) && !start_push_o && iret_i && !empty_i;
  assign last_idx     = IDX_W'(PC_BYTES) + IDX_W'(ext_q);
  assign finish_o     = ((state_q == ST_PUSH) || (state_q == ST_POP)) && (idx_q == last_idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      ext_q   <= 1'b0;
      entry_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          idx_q <= '0;
          if (start_push_o) begin
            state_q <= ST_PUSH;
            ext_q   <= mode_i;
            entry_q <= 1'b1;
          end else if (start_pop) begin
            state_q <= ST_POP;
            ext_q   <= top_ext_i;
            entry_q <= 1'b0;
          end
        end
        ST_PUSH, ST_POP: begin
          if (finish_o) state_q <= ST_WB;
          else          idx_q   <= idx_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign idx_o   = idx_q;
  assign ext_o   = ext_q;
  assign entry_o = entry_q;
endmodule

// File: rtl/intr_frame_seq.sv
module intr_frame_seq import ifs_pkg::*; #(
  parameter int unsigned    PC_W       = 16,
  parameter int unsigned    FLAG_W     = 8,
  parameter int unsigned    SEG_W      = 6,
  parameter int unsigned    SP_W       = 8,
  parameter logic [SP_W-1:0] SP_INIT   = 8'hF0,
  parameter int unsigned    NEST_DEPTH = 8,
  localparam int unsigned   PC_BYTES   = PC_W / 8,
  localparam int unsigned   IDX_W      = $clog2(PC_BYTES + 2),
  localparam int unsigned   DEPTH_W    = $clog2(NEST_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_we_i,
  input  logic              mode_d_i,
  input  logic              irq_i,
  input  logic              iret_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [SEG_W-1:0]  csr_i,
  input  logic [SEG_W-1:0]  isr_i,
  output logic              stk_we_o,
  output logic              stk_re_o,
  output logic [SP_W-1:0]   stk_addr_o,
  output logic [7:0]        stk_wdata_o,
  input  logic [7:0]        stk_rdata_i,
  output logic [SP_W-1:0]   sp_o,
  output logic              busy_o,
  output logic              pc_we_o,
  output logic [PC_W-1:0]   pc_o,
  output logic              flags_we_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              csr_we_o,
  output logic [SEG_W-1:0]  csr_o,
  output logic [SEG_W-1:0]  fetch_seg_o,
  output logic [SEG_W-1:0]  vec_seg_o
);
  ifs_state_e         state;
  logic [IDX_W-1:0]   idx;
  logic [IDX_W-1:0]   sel;
  logic               ext, entry, start_push, finish;
  logic               full, empty, top_ext;
  logic [DEPTH_W-1:0] depth;
  logic [SP_W-1:0]    sp_q;
  logic               mode_q;
  logic [PC_W-1:0]    pc_q;
  logic [FLAG_W-1:0]  flags_q;
  logic [SEG_W-1:0]   csr_q;
  logic [SEG_W-1:0]   isr_q;
  logic [SP_W-1:0]    frame_len;

  ifs_ctrl #(.PC_BYTES(PC_BYTES)) u_ctrl (
    .clk_i, .rst_ni, .irq_i, .iret_i,
    .mode_i       (mode_q),
    .full_i       (full),
    .empty_i      (empty),
    .top_ext_i    (top_ext),
    .state_o      (state),
    .idx_o        (idx),
    .ext_o        (ext),
    .entry_o      (entry),
    .start_push_o (start_push),
    .finish_o     (finish)
  );

  ifs_level_stack #(.NEST_DEPTH(NEST_DEPTH)) u_levels (
    .clk_i, .rst_ni,
    .push_i    (finish && entry),
    .pop_i     (finish && !entry),
    .ext_i     (ext),
    .depth_o   (depth),
    .full_o    (full),
    .empty_o   (empty),
    .top_ext_o (top_ext)
  );

  ifs_frame_mux #(
    .PC_W(PC_W), .FLAG_W(FLAG_W), .SEG_W(SEG_W), .SP_W(SP_W)
  ) u_mux (
    .push_i  (state == ST_PUSH),
    .ext_i   (ext),
    .idx_i   (idx),
    .sp_i    (sp_q),
    .pc_i    (pc_q),
    .flags_i (flags_q),
    .seg_i   (csr_q),
    .sel_o   (sel),
    .addr_o  (stk_addr_o),
    .wdata_o (stk_wdata_o)
  );

  assign frame_len = SP_W'(PC_BYTES + 1) + SP_W'(ext);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= 1'b0;
    else if (mode_we_i) mode_q <= mode_d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q <= SP_INIT;
    end else if (finish) begin
      sp_q <= entry ? (sp_q - frame_len) : (sp_q + frame_len);
    end
  end

  // frame registers: loaded from the CPU on entry, from the stack on return
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      flags_q <= '0;
      csr_q   <= '0;
      isr_q   <= '0;
    end else if (start_push) begin
      pc_q    <= pc_i;
      flags_q <= flags_i;
      csr_q   <= csr_i;
      isr_q   <= isr_i;
    end else if (state == ST_POP) begin
      for (int b = 0; b < PC_BYTES; b++) begin
        if (sel == IDX_W'(b)) pc_q[b*8 +: 8] <= stk_rdata_i;
      end
      if (sel == IDX_W'(PC_BYTES))     flags_q <= stk_rdata_i[FLAG_W-1:0];
      if (sel == IDX_W'(PC_BYTES + 1)) csr_q   <= stk_rdata_i[SEG_W-1:0];
    end
  end

  assign stk_we_o    = (state == ST_PUSH);
  assign stk_re_o    = (state == ST_POP);
  assign busy_o      = stk_we_o || stk_re_o;
  assign sp_o        = sp_q;
  assign pc_we_o     = (state == ST_WB) && !entry;
  assign flags_we_o  = (state == ST_WB) && !entry;
  assign csr_we_o    = (state == ST_WB) && ext;
  assign pc_o        = pc_q;
  assign flags_o     = flags_q;
  assign csr_o       = entry ? isr_q : csr_q;
  assign fetch_seg_o = (!empty && !top_ext) ? isr_i : csr_i;
  assign vec_seg_o   = isr_i;
endmodule

// File: rtl/ifs_checker.sv
module ifs_checker #(
  parameter int unsigned SP_W    = 8,
  parameter int unsigned DEPTH_W = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               irq_i,
  input logic               iret_i,
  input logic               busy_i,
  input logic               stk_we_i,
  input logic               stk_re_i,
  input logic [SP_W-1:0]    stk_addr_i,
  input logic [SP_W-1:0]    sp_i,
  input logic               pc_we_i,
  input logic               flags_we_i,
  input logic               csr_we_i,
  input logic [DEPTH_W-1:0] depth_i,
  input logic               full_i
);
  p_port_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stk_we_i && stk_re_i));

  p_access_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stk_we_i || stk_re_i) |-> busy_i);

  p_push_desc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stk_we_i && $past(stk_we_i)) |-> (stk_addr_i == $past(stk_addr_i) - SP_W'(1)));

  p_pop_asc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stk_re_i && $past(stk_re_i)) |-> (stk_addr_i == $past(stk_addr_i) + SP_W'(1)));

  p_restore_after_pop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_we_i |-> ($past(stk_re_i) && flags_we_i));

  p_sp_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !$past(busy_i)) |-> $stable(sp_i));

  p_iret_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iret_i && !irq_i && depth_i == '0 && !busy_i) |=> !busy_i);

  p_irq_full_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && !iret_i && full_i && !busy_i) |=> !busy_i);
endmodule

bind intr_frame_seq ifs_checker #(.SP_W(SP_W), .DEPTH_W(DEPTH_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .irq_i      (irq_i),
  .iret_i     (iret_i),
  .busy_i     (busy_o),
  .stk_we_i   (stk_we_o),
  .stk_re_i   (stk_re_o),
  .stk_addr_i (stk_addr_o),
  .sp_i       (sp_o),
  .pc_we_i    (pc_we_o),
  .flags_we_i (flags_we_o),
  .csr_we_i   (csr_we_o),
  .depth_i    (depth),
  .full_i     (full)
);

// File: tb/tb_intr_frame_seq.sv
module tb_intr_frame_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NEST       = 8;
  localparam logic [7:0] SP0 = 8'hF0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_we, mode_d, irq, iret;
  logic [15:0] pc_in;
  logic [7:0]  flags_in;
  logic [5:0]  cpu_csr, isr_in;
  logic        stk_we, stk_re, busy, pc_we, flags_we, csr_we;
  logic [7:0]  stk_addr, stk_wdata, stk_rdata, sp;
  logic [15:0] pc_out;
  logic [7:0]  flags_out;
  logic [5:0]  csr_out, fetch_seg, vec_seg;
  logic [7:0]  mem [256];

  int errors = 0;
  int checks = 0;
  int store_cnt = 0;
  bit m_mode = 1'b0;
  int m_depth = 0;
  logic [15:0] m_pc [NEST];
  logic [7:0]  m_fl [NEST];
  logic [5:0]  m_cs [NEST];
  bit          m_ext [NEST];

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_frame_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_we_i(mode_we), .mode_d_i(mode_d),
    .irq_i(irq), .iret_i(iret), .pc_i(pc_in), .flags_i(flags_in),
    .csr_i(cpu_csr), .isr_i(isr_in), .stk_we_o(stk_we), .stk_re_o(stk_re),
    .stk_addr_o(stk_addr), .stk_wdata_o(stk_wdata), .stk_rdata_i(stk_rdata),
    .sp_o(sp), .busy_o(busy), .pc_we_o(pc_we), .pc_o(pc_out),
    .flags_we_o(flags_we), .flags_o(flags_out), .csr_we_o(csr_we),
    .csr_o(csr_out), .fetch_seg_o(fetch_seg), .vec_seg_o(vec_seg)
  );

  assign stk_rdata = mem[stk_addr];

  always @(posedge clk) begin
    if (stk_we) begin
      mem[stk_addr] <= stk_wdata;
      store_cnt <= store_cnt + 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cpu_csr <= 6'h05;
    else if (csr_we) cpu_csr <= csr_out;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_fetch();
    if (m_depth > 0 && !m_ext[m_depth-1]) return isr_in;
    return cpu_csr;
  endfunction

  task automatic set_mode(input bit b);
    @(negedge clk); mode_we = 1'b1; mode_d = b;
    @(negedge clk); mode_we = 1'b0;
    m_mode = b;
  endtask

  task automatic enter(input bit with_iret);
    logic [7:0] s0;
    int n;
    bit e;
    @(negedge clk);
    pc_in = 16'($urandom); flags_in = 8'($urandom); isr_in = 6'($urandom);
    s0 = sp; e = m_mode;
    m_pc[m_depth] = pc_in; m_fl[m_depth] = flags_in;
    m_cs[m_depth] = cpu_csr; m_ext[m_depth] = e;
    irq = 1'b1; iret = with_iret;
    @(negedge clk); irq = 1'b0; iret = 1'b0;
    n = 0;
    while (busy && n < 10) begin n++; @(negedge clk); end
    chk(n == (e ? 4 : 3), e ? "R3 busy len" : "R2 busy len", n, e ? 4 : 3);
    chk(csr_we == e, e ? "R3 csr load" : "R2 no csr load", csr_we, e);
    if (e) chk(csr_out == isr_in, "R3 csr value", csr_out, isr_in);
    chk(sp == s0 - (e ? 8'd4 : 8'd3), "R2 R3 sp", sp, s0 - (e ? 8'd4 : 8'd3));
    chk(mem[s0-8'd1] == m_pc[m_depth][7:0], "R2 pc low", mem[s0-8'd1], m_pc[m_depth][7:0]);
    chk(mem[s0-8'd2] == m_pc[m_depth][15:8], "R2 pc high", mem[s0-8'd2], m_pc[m_depth][15:8]);
    chk(mem[s0-8'd3] == m_fl[m_depth], "R2 flags", mem[s0-8'd3], m_fl[m_depth]);
    if (e) chk(mem[s0-8'd4] == {2'b00, m_cs[m_depth]}, "R3 seg byte", mem[s0-8'd4], m_cs[m_depth]);
    m_depth++;
    @(negedge clk);
    chk(fetch_seg == exp_fetch(), "R4 fetch seg after entry", fetch_seg, exp_fetch());
    chk(vec_seg == isr_in, "R7 vector seg", vec_seg, isr_in);
  endtask

  task automatic leave();
    logic [7:0] s0;
    int n, t;
    bit e;
    @(negedge clk);
    s0 = sp; t = m_depth - 1; e = m_ext[t];
    isr_in = 6'($urandom);
    iret = 1'b1;
    @(negedge clk); iret = 1'b0;
    n = 0;
    while (busy && n < 10) begin n++; @(negedge clk); end
    chk(n == (e ? 4 : 3), "R6 pop count", n, e ? 4 : 3);
    chk(pc_we && flags_we, "R5 restore strobes", {pc_we, flags_we}, 2'b11);
    chk(pc_out == m_pc[t], "R5 R12 pc", pc_out, m_pc[t]);
    chk(flags_out == m_fl[t], "R5 R12 flags", flags_out, m_fl[t]);
    chk(csr_we == e, "R6 csr restore", csr_we, e);
    if (e) chk(csr_out == m_cs[t], "R5 csr value", csr_out, m_cs[t]);
    chk(sp == s0 + (e ? 8'd4 : 8'd3), "R5 sp", sp, s0 + (e ? 8'd4 : 8'd3));
    m_depth--;
    @(negedge clk);
    chk(fetch_seg == exp_fetch(), "R4 fetch seg after return", fetch_seg, exp_fetch());
  endtask

  task automatic ignored(input bit is_irq, input string req);
    logic [7:0] s0;
    int w0;
    @(negedge clk);
    s0 = sp; w0 = store_cnt;
    if (is_irq) irq = 1'b1; else iret = 1'b1;
    @(negedge clk); irq = 1'b0; iret = 1'b0;
    chk(!busy, req, busy, 0);
    @(negedge clk);
    chk(!busy && !pc_we && !csr_we, req, {busy, pc_we, csr_we}, 0);
    chk(sp == s0, req, sp, s0);
    chk(store_cnt == w0, req, store_cnt, w0);
  endtask

  initial begin
    void'($urandom(32'd7321));
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    mode_we = 0; mode_d = 0; irq = 0; iret = 0;
    pc_in = 16'h1234; flags_in = 8'h5A; isr_in = 6'h2A;
    repeat (3) @(negedge clk);
    chk(!busy && !stk_we && !stk_re && !pc_we && !csr_we, "R1 idle outputs", busy, 0);
    chk(sp == SP0, "R1 sp", sp, SP0);
    chk(fetch_seg == cpu_csr, "R1 fetch seg", fetch_seg, cpu_csr);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && sp == SP0, "R1 after release", sp, SP0);
    // mode bit is 0 out of reset: compact frame expected
    enter(1'b0);
    leave();
    set_mode(1'b1);
    enter(1'b0);
    set_mode(1'b0);
    enter(1'b0);
    leave();
    leave();
    // R6: mode flipped inside handlers
    enter(1'b0);
    set_mode(1'b1);
    leave();
    enter(1'b0);
    set_mode(1'b0);
    leave();
    // R8
    ignored(1'b0, "R8 iret empty");
    // R10
    enter(1'b0);
    enter(1'b1);
    chk(m_depth == 2, "R10 irq wins", m_depth, 2);
    leave();
    leave();
    // R9, R12: fill to the limit
    for (int i = 0; i < NEST; i++) begin
      set_mode(1'($urandom));
      enter(1'b0);
    end
    ignored(1'b1, "R9 irq full");
    for (int i = 0; i < NEST; i++) leave();
    chk(sp == SP0, "R12 sp balanced", sp, SP0);
    // random mix
    for (int i = 0; i < 80; i++) begin
      int r;
      r = int'($urandom % 8);
      if (r == 0) set_mode(~m_mode);
      else if (r < 5) begin
        if (m_depth < NEST) enter(1'b0); else ignored(1'b1, "R9 irq full");
      end else begin
        if (m_depth > 0) leave(); else ignored(1'b0, "R8 iret empty");
      end
    end
    while (m_depth > 0) leave();
    chk(sp == SP0, "R12 final sp", sp, SP0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog act=running exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule